// File: doc/BRIEF.md
# Lockable Translation Buffer with Victim Steering

This block is a fully associative translation buffer for 32-bit device virtual addresses. Software fills it through a small configuration port: it writes a tag word and a translation word into holding registers, then pulses a load strobe. The slot that receives the pair comes from a lock register. That register holds two indices: a base index, below which slots are protected, and a victim index, which names the next slot to fill. Each entry covers a page of 4 KB, 64 KB, 1 MB or 16 MB. A lookup port takes a virtual address and, one cycle later, returns hit, the translated physical address and the entry's attribute bits.

A per-cycle operation selector in the lock controller decides how the lock state moves. Its states are `OP_IDLE`, `OP_WIPE`, `OP_FILL_KEEP` and `OP_FILL_ROT`. `OP_WIPE` is taken when the global flush strobe is high, and it beats every other strobe. `OP_FILL_KEEP` is taken on a load whose tag word has its protect bit set: the entry goes into the base slot and the protected region grows by one. `OP_FILL_ROT` is taken on an ordinary load: the entry goes into the victim slot and the victim index advances, wrapping back to the base. `OP_IDLE` leaves the indices alone, except that a write to the lock register takes effect in `OP_IDLE` and in `OP_WIPE`. The selector runs again on every clock edge, so each transition lasts one cycle and returns to the choice made from the next cycle's strobes. Read-back of the tag word and translation word always shows the entry the victim index points at. Setting the victim index therefore lets software inspect any slot.

Top module: `lock_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the lock read-back word is zero.
- R2: The lock register is written with `cfg_sel`=2. The base index sits in bits 14:10 and the victim index in bits 8:4, and `lock_rb` returns them in the same positions with all other bits zero.
- R3: On an ordinary load, the pair goes into the victim slot. If the victim index is below the base, the pair goes into the base slot instead. Slots below the base are never written by an ordinary load.
- R4: After an ordinary load into slot t, the victim index becomes t+1. When t is the last slot, the victim index becomes the base index.
- R5: A load whose tag word has bit 3 set (protect) writes the base slot. Afterwards the base index and the victim index both equal the old base plus one. The base stops at the last slot.
- R6: `cam_rb` returns the entry at the victim index in tag-word format: tag in bits 31:12, protect in bit 3, valid in bit 2, size code in bits 1:0, all other bits zero. `ram_rb` returns that entry's translation word.
- R7: Size code 00 selects 4 KB, 01 selects 64 KB, 10 selects 1 MB and 11 selects 16 MB. The tag compare ignores the virtual address bits below the page size.
- R8: A hit returns a physical address built from two parts: the translation word's bits above the page size, and the virtual address bits below it. The hit also returns translation word bits 11:0 as attributes. The results and `lk_vld` appear on the cycle after `lk_req`.
- R9: A per-entry flush invalidates every valid entry whose tag matches the held tag word, compared at that entry's own page size. Other entries are untouched.
- R10: A global flush invalidates all entries.
- R11: When a global flush and a load arrive in the same cycle, the flush wins. No entry is written and both lock indices stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | 0 tag word, 1 translation word, 2 lock register, 3 ignored |
| cfg_wdata | input | 32 | Configuration write data |
| load_stb | input | 1 | Load the held words into the chosen slot |
| flush_one_stb | input | 1 | Invalidate entries matching the held tag |
| flush_all_stb | input | 1 | Invalidate all entries |
| cam_rb | output | 32 | Tag word of the entry at the victim index |
| ram_rb | output | 32 | Translation word of the entry at the victim index |
| lock_rb | output | 32 | Lock register read-back |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 12 | Attribute bits of the hit entry |

## Verification
A global flush and a load can fall in the same cycle, because the two strobes are separate pins. The bench first stages a new tag word and translation word. It then raises both strobes on one clock edge while the lock holds a non-zero base and victim. The result is judged only at the ports. Lookups of the staged address and of earlier entries must all miss, and `lock_rb` must be unchanged. A later load on its own must then land in the slot the victim still names.

// File: rtl/ltlb_pkg.sv
package ltlb_pkg;

    localparam int ADDR_W = 32;
    localparam int TAG_W  = 20;
    localparam int ATTR_W = 12;

    typedef enum logic [1:0] {
        PG_4K  = 2'b00,
        PG_64K = 2'b01,
        PG_1M  = 2'b10,
        PG_16M = 2'b11
    } pg_size_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_WIPE,
        OP_FILL_KEEP,
        OP_FILL_ROT
    } lock_op_e;

    // Mask over tag bits (VA 31:12) that take part in the compare
    function automatic logic [TAG_W-1:0] tag_mask(input logic [1:0] sz);
        logic [TAG_W-1:0] m;
        case (pg_size_e'(sz))
            PG_4K:   m = 20'hFFFFF;
            PG_64K:  m = 20'hFFFF0;
            PG_1M:   m = 20'hFFF00;
            default: m = 20'hFF000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl
    import ltlb_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    localparam int IW = $clog2(N_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_stb,
    input  logic          wipe_stb,
    input  logic          keep_bit,
    input  logic          lock_we,
    input  logic [4:0]    base_in,
    input  logic [4:0]    vict_in,
    output logic [IW-1:0] base,
    output logic [IW-1:0] victim,
    output logic          fill_en,
    output logic [IW-1:0] fill_idx,
    output logic          wipe_all
);

    localparam logic [IW-1:0] LAST = IW'(N_ENTRIES - 1);

    lock_op_e      op;
    logic [IW-1:0] base_n, victim_n, rot_tgt;

    always_comb begin
        if (wipe_stb)      op = OP_WIPE;
        else if (load_stb) op = keep_bit ? OP_FILL_KEEP : OP_FILL_ROT;
        else               op = OP_IDLE;
    end

    assign rot_tgt = (victim < base) ? base : victim;

    always_comb begin
        base_n   = base;
        victim_n = victim;
        fill_en  = 1'b0;
        fill_idx = '0;
        wipe_all = 1'b0;
        unique case (op)
            OP_IDLE: begin
                if (lock_we) begin
                    base_n   = base_in[IW-1:0];
                    victim_n = vict_in[IW-1:0];
                end
            end
            OP_WIPE: begin
                wipe_all = 1'b1;
                if (lock_we) begin
                    base_n   = base_in[IW-1:0];
                    victim_n = vict_in[IW-1:0];
                end
            end
            OP_FILL_KEEP: begin
                fill_en  = 1'b1;
                fill_idx = base;
                base_n   = (base == LAST) ? base : base + 1'b1;
                victim_n = (base == LAST) ? base : base + 1'b1;
            end
            OP_FILL_ROT: begin
                fill_en  = 1'b1;
                fill_idx = rot_tgt;
                victim_n = (rot_tgt == LAST) ? base : rot_tgt + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            victim <= '0;
        end else begin
            base   <= base_n;
            victim <= victim_n;
        end
    end

    // R4
    victim_not_below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FILL_ROT) |=> (victim >= base));

    // R5
    keep_grows_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FILL_KEEP && base != LAST) |=> (base == $past(base) + 1'b1));

    // R11
    wipe_holds_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_stb && load_stb && !lock_we) |=> (victim == $past(victim) && base == $past(base)));

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import ltlb_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    localparam int IW = $clog2(N_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wipe_all,
    input  logic                              fill_en,
    input  logic [IW-1:0]                     fill_idx,
    input  logic [TAG_W-1:0]                  fill_tag,
    input  logic                              fill_keep,
    input  logic                              fill_valid,
    input  logic [1:0]                        fill_sz,
    input  logic [ADDR_W-1:0]                 fill_ram,
    input  logic                              zap_stb,
    input  logic [TAG_W-1:0]                  zap_tag,
    output logic [N_ENTRIES-1:0]              e_valid,
    output logic [N_ENTRIES-1:0]              e_keep,
    output logic [N_ENTRIES-1:0][TAG_W-1:0]   e_tag,
    output logic [N_ENTRIES-1:0][1:0]         e_sz,
    output logic [N_ENTRIES-1:0][ADDR_W-1:0]  e_ram
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        logic zap_hit;
        assign zap_hit = e_valid[i] &&
                         (((e_tag[i] ^ zap_tag) & tag_mask(e_sz[i])) == '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[i] <= 1'b0;
                e_keep[i]  <= 1'b0;
                e_tag[i]   <= '0;
                e_sz[i]    <= '0;
                e_ram[i]   <= '0;
            end else if (wipe_all) begin
                e_valid[i] <= 1'b0;
            end else if (fill_en && fill_idx == IW'(i)) begin
                e_valid[i] <= fill_valid;
                e_keep[i]  <= fill_keep;
                e_tag[i]   <= fill_tag;
                e_sz[i]    <= fill_sz;
                e_ram[i]   <= fill_ram;
            end else if (zap_stb && zap_hit) begin
                e_valid[i] <= 1'b0;
            end
        end
    end

    // R10
    wipe_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_all |=> (e_valid == '0));

    // R3
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !wipe_all) |=> (e_ram[$past(fill_idx)] == $past(fill_ram)));

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import ltlb_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    localparam int IW = $clog2(N_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req,
    input  logic [ADDR_W-1:0]                 va,
    input  logic [N_ENTRIES-1:0]              e_valid,
    input  logic [N_ENTRIES-1:0][TAG_W-1:0]   e_tag,
    input  logic [N_ENTRIES-1:0][1:0]         e_sz,
    input  logic [N_ENTRIES-1:0][ADDR_W-1:0]  e_ram,
    output logic                              vld,
    output logic                              hit,
    output logic [ADDR_W-1:0]                 pa,
    output logic [ATTR_W-1:0]                 attr
);

    logic [N_ENTRIES-1:0] match;
    logic                 found;
    logic [IW-1:0]        sel;
    logic [ADDR_W-1:0]    mask_full;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign match[i] = e_valid[i] &&
            (((va[ADDR_W-1:ATTR_W] ^ e_tag[i]) & tag_mask(e_sz[i])) == '0);
    end

    // lowest index wins on multiple hits
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                sel   = IW'(i);
            end
        end
    end

    assign mask_full = {tag_mask(e_sz[sel]), {ATTR_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            hit  <= 1'b0;
            pa   <= '0;
            attr <= '0;
        end else begin
            vld <= req;
            hit <= req && found;
            if (req) begin
                pa   <= (e_ram[sel] & mask_full) | (va & ~mask_full);
                attr <= e_ram[sel][ATTR_W-1:0];
            end
        end
    end

    // R8
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> vld);

    // R8
    hit_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> vld);

endmodule

// File: rtl/lock_tlb.sv
module lock_tlb
    import ltlb_pkg::*;
#(
    parameter int N_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        load_stb,
    input  logic        flush_one_stb,
    input  logic        flush_all_stb,
    output logic [31:0] cam_rb,
    output logic [31:0] ram_rb,
    output logic [31:0] lock_rb,
    input  logic        lk_req,
    input  logic [31:0] lk_va,
    output logic        lk_vld,
    output logic        lk_hit,
    output logic [31:0] lk_pa,
    output logic [11:0] lk_attr
);

    localparam int IW = $clog2(N_ENTRIES);

    localparam logic [1:0] SEL_CAM  = 2'd0;
    localparam logic [1:0] SEL_RAM  = 2'd1;
    localparam logic [1:0] SEL_LOCK = 2'd2;

    logic [TAG_W-1:0]  cam_tag_q;
    logic              cam_keep_q, cam_valid_q;
    logic [1:0]        cam_sz_q;
    logic [ADDR_W-1:0] ram_q;

    logic [IW-1:0] base, victim, fill_idx;
    logic          fill_en, wipe_all;

    logic [N_ENTRIES-1:0]             e_valid, e_keep;
    logic [N_ENTRIES-1:0][TAG_W-1:0]  e_tag;
    logic [N_ENTRIES-1:0][1:0]        e_sz;
    logic [N_ENTRIES-1:0][ADDR_W-1:0] e_ram;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cam_tag_q   <= '0;
            cam_keep_q  <= 1'b0;
            cam_valid_q <= 1'b0;
            cam_sz_q    <= '0;
            ram_q       <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_CAM) begin
                cam_tag_q   <= cfg_wdata[31:12];
                cam_keep_q  <= cfg_wdata[3];
                cam_valid_q <= cfg_wdata[2];
                cam_sz_q    <= cfg_wdata[1:0];
            end
            if (cfg_sel == SEL_RAM) ram_q <= cfg_wdata;
        end
    end

    tlb_lock_ctrl #(.N_ENTRIES(N_ENTRIES)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .wipe_stb (flush_all_stb),
        .keep_bit (cam_keep_q),
        .lock_we  (cfg_we && cfg_sel == SEL_LOCK),
        .base_in  (cfg_wdata[14:10]),
        .vict_in  (cfg_wdata[8:4]),
        .base     (base),
        .victim   (victim),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .wipe_all (wipe_all)
    );

    tlb_entry_array #(.N_ENTRIES(N_ENTRIES)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe_all   (wipe_all),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_tag   (cam_tag_q),
        .fill_keep  (cam_keep_q),
        .fill_valid (cam_valid_q),
        .fill_sz    (cam_sz_q),
        .fill_ram   (ram_q),
        .zap_stb    (flush_one_stb),
        .zap_tag    (cam_tag_q),
        .e_valid    (e_valid),
        .e_keep     (e_keep),
        .e_tag      (e_tag),
        .e_sz       (e_sz),
        .e_ram      (e_ram)
    );

    tlb_lookup #(.N_ENTRIES(N_ENTRIES)) u_look (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (lk_req),
        .va      (lk_va),
        .e_valid (e_valid),
        .e_tag   (e_tag),
        .e_sz    (e_sz),
        .e_ram   (e_ram),
        .vld     (lk_vld),
        .hit     (lk_hit),
        .pa      (lk_pa),
        .attr    (lk_attr)
    );

    assign cam_rb  = {e_tag[victim], 8'd0, e_keep[victim], e_valid[victim], e_sz[victim]};
    assign ram_rb  = e_ram[victim];
    assign lock_rb = {17'd0, 5'(base), 1'b0, 5'(victim), 4'd0};

    // R5
    keep_fill_at_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !flush_all_stb && cam_keep_q) |-> (fill_idx == base));

endmodule

// File: tb/sim_lock_tlb.sv
module sim_lock_tlb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        load_stb, flush_one_stb, flush_all_stb;
    logic [31:0] cam_rb, ram_rb, lock_rb;
    logic        lk_req;
    logic [31:0] lk_va;
    logic        lk_vld, lk_hit;
    logic [31:0] lk_pa;
    logic [11:0] lk_attr;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    lock_tlb u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .load_stb(load_stb), .flush_one_stb(flush_one_stb),
        .flush_all_stb(flush_all_stb), .cam_rb(cam_rb), .ram_rb(ram_rb),
        .lock_rb(lock_rb), .lk_req(lk_req), .lk_va(lk_va), .lk_vld(lk_vld),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        hit;
        logic [31:0] pa;
        logic [11:0] attr;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{32'h1234_5ABC, 1'b1, 32'h8000_0ABC, 12'h0A5},
        '{32'h1234_6000, 1'b0, 32'h0,         12'h0},
        '{32'h0002_F123, 1'b1, 32'h9001_F123, 12'h011},
        '{32'h0003_0000, 1'b0, 32'h0,         12'h0},
        '{32'h405F_FFFF, 1'b1, 32'hA03F_FFFF, 12'h022},
        '{32'h4060_0000, 1'b0, 32'h0,         12'h0},
        '{32'h7FAB_CDEF, 1'b1, 32'h05AB_CDEF, 12'h033},
        '{32'h8000_0000, 1'b0, 32'h0,         12'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic ld, input logic f1, input logic fa);
        load_stb = ld; flush_one_stb = f1; flush_all_stb = fa;
        @(negedge clk);
        load_stb = 1'b0; flush_one_stb = 1'b0; flush_all_stb = 1'b0;
    endtask

    task automatic fill(input logic [31:0] cam, input logic [31:0] ram);
        wr(2'd0, cam);
        wr(2'd1, ram);
        pulse(1'b1, 1'b0, 1'b0);
    endtask

    task automatic look(input logic [31:0] va);
        lk_req = 1'b1; lk_va = va;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] va,
                              input logic [31:0] pa, input logic [11:0] attr);
        look(va);
        chk(tag, {31'd0, lk_vld}, 32'd1);
        chk(tag, {31'd0, lk_hit}, 32'd1);
        chk(tag, lk_pa, pa);
        chk(tag, {20'd0, lk_attr}, {20'd0, attr});
    endtask

    task automatic expect_miss(input string tag, input logic [31:0] va);
        look(va);
        chk(tag, {31'd0, lk_hit}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        load_stb = 1'b0; flush_one_stb = 1'b0; flush_all_stb = 1'b0;
        lk_req = 1'b0; lk_va = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 lock", lock_rb, 32'h0);
        expect_miss("R1 miss", 32'h1234_5ABC);
        chk("R1 vld", {31'd0, lk_vld}, 32'd1);

        // Fill four rotating entries, one per page size (R3, R7)
        fill(32'h1234_5004, 32'h8000_00A5); // 4K  -> slot 0
        fill(32'h0002_0005, 32'h9001_0011); // 64K -> slot 1
        fill(32'h4050_0006, 32'hA030_0022); // 1M  -> slot 2
        fill(32'h7F00_0007, 32'h0500_0033); // 16M -> slot 3
        chk("R4 victim after four", lock_rb, 32'h0000_0040);

        for (int k = 0; k < 8; k++) begin
            look(VEC[k].va);
            chk("R7 hit", {31'd0, lk_hit}, {31'd0, VEC[k].hit});
            if (VEC[k].hit) begin
                chk("R8 pa", lk_pa, VEC[k].pa);
                chk("R8 attr", {20'd0, lk_attr}, {20'd0, VEC[k].attr});
            end
        end

        // R6 read-back via victim, R2 lock layout
        wr(2'd2, 32'h0000_0020);
        chk("R2 lock rb", lock_rb, 32'h0000_0020);
        chk("R6 cam rb", cam_rb, 32'h4050_0006);
        chk("R6 ram rb", ram_rb, 32'hA030_0022);
        wr(2'd2, 32'h0000_0040);

        // R5 protected load goes to base 0, base and victim become 1
        fill(32'h0000_100C, 32'hC000_0044);
        chk("R5 lock", lock_rb, 32'h0000_0410);
        expect_hit("R5 keep entry", 32'h0000_1FFF, 32'hC000_0FFF, 12'h044);
        expect_miss("R5 old slot0", 32'h1234_5ABC);

        // R3 victim below base redirects to base
        wr(2'd2, 32'h0000_0400);
        fill(32'h0BAD_0005, 32'h1111_0055);
        chk("R3 lock", lock_rb, 32'h0000_0420);
        expect_hit("R3 keep survives", 32'h0000_1000, 32'hC000_0000, 12'h044);
        expect_hit("R3 new entry", 32'h0BAD_1234, 32'h1111_1234, 12'h055);
        expect_miss("R3 slot1 replaced", 32'h0002_0000);
        wr(2'd2, 32'h0000_0400);
        chk("R6 keep rb", cam_rb, 32'h0000_100C);

        // R4 wrap from last slot to base
        wr(2'd2, 32'h0000_05F0);
        fill(32'h2222_2004, 32'h3333_3066);
        chk("R4 wrap", lock_rb, 32'h0000_0410);
        expect_hit("R4 slot31", 32'h2222_2004, 32'h3333_3004, 12'h066);

        // R9 entry flush by tag inside the 1M page
        wr(2'd0, 32'h4055_5000);
        pulse(1'b0, 1'b1, 1'b0);
        expect_miss("R9 flushed", 32'h4050_0000);
        expect_hit("R9 others kept", 32'h7F00_0000, 32'h0500_0000, 12'h033);

        // R11 global flush and load together; R10 all invalid
        wr(2'd0, 32'h6666_6004);
        wr(2'd1, 32'h7777_7000);
        pulse(1'b1, 1'b0, 1'b1);
        chk("R11 lock kept", lock_rb, 32'h0000_0410);
        expect_miss("R11 no load", 32'h6666_6000);
        expect_miss("R10 16M gone", 32'h7F00_0000);
        expect_miss("R10 slot31 gone", 32'h2222_2004);
        expect_miss("R10 keep gone", 32'h0000_1000);

        pulse(1'b1, 1'b0, 1'b0);
        chk("R4 after flush", lock_rb, 32'h0000_0420);
        expect_hit("R3 load after flush", 32'h6666_6123, 32'h7777_7123, 12'h000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule